// File: doc/BRIEF.md
# Descriptor-Driven Frame Transmit Sequencer

This block moves outgoing Ethernet frames from system memory to a byte-wide PHY-side stream. Software fills a small local table of transmit descriptors. Each descriptor has a control/status word, which carries the length, the ownership flag and option flags, and a buffer pointer word. Software then sets the transmit-enable bit in the mode register. The sequencer visits the descriptors in ring order. When the current descriptor is owned by hardware, it checks the frame length against the configured limits. It then fetches the frame one byte at a time through a request/response memory port and hands each byte over a valid/ready stream. When the frame ends, it writes status back into the descriptor and raises a sticky interrupt-source bit.

A frame ends either with every byte delivered, or early when the PHY side raises an abort or the length is out of range. An early end marks the frame as failed and clears the descriptor's collision flag. A delayed-CRC option from the mode register is recorded per frame in the descriptor status; no CRC is computed. Retry, backoff and line timing are left to other blocks.

Top module: `txseq_top`

## Requirements
- R1: After reset, irq, tx_valid, tx_last and mem_req are 0. The mode, interrupt-source, mask, limit and count registers read as 0.
- R2: While mode bit 0 (transmit enable) is 0, no memory request is issued and no descriptor is modified, even if a descriptor is ready.
- R3: The sequencer does not move past the current descriptor while its ready bit (bit 15 of the control word) is 0. Once software sets that bit, the frame is sent.
- R4: A frame of length L (control word bits 31:16) is sent as L bytes read from consecutive byte addresses, starting at the buffer pointer, in ascending order. tx_last marks the final byte, and tx_data and tx_last are held while tx_valid waits for tx_ready. Only one memory request is outstanding at a time.
- R5: A fully delivered frame clears the ready bit, leaves the other control-word fields unchanged, and sets interrupt-source bit 0 (done).
- R6: If tx_abort is seen while a frame is being fetched or sent, no further bytes are offered. The ready bit and the collision bit (bit 11) are cleared, and interrupt-source bit 1 (error) is set.
- R7: A length below the minimum (limit register bits 31:16) or above the maximum (bits 15:0) sends no byte and takes the error path of R6.
- R8: The control word written back holds in bit 12 the value that mode bit 2 (delayed CRC) had when the descriptor was accepted.
- R9: After each completion the descriptor index advances by one. It returns to 0 when the descriptor's wrap bit (bit 13) is set, or when the next index would reach the descriptor count register (a count of 0 or above the table size means the full table).
- R10: Interrupt-source bits are sticky. Writing 1 to a bit clears it, and writing 0 has no effect. irq is high exactly when a source bit and its matching mask bit are both set.
- R11: While mode bit 1 (soft reset) is set, the sequencer is held idle with descriptor index 0. After the bit is released, transmission restarts from descriptor 0.

Register word addresses: 0 mode, 1 interrupt source, 2 interrupt mask, 3 length limits, 4 descriptor count. Descriptor n has its control word at 8+2n and its pointer word at 9+2n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register/descriptor write strobe |
| csr_addr | input | CSR_AW | Word address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for csr_addr (combinational) |
| mem_req | output | 1 | One-cycle byte read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 8 | Read response byte |
| tx_valid | output | 1 | Byte offered to the PHY side |
| tx_data | output | 8 | Offered byte |
| tx_last | output | 1 | Offered byte ends the frame |
| tx_ready | input | 1 | PHY side accepts the byte |
| tx_abort | input | 1 | PHY side abandons the current frame |
| irq | output | 1 | Masked interrupt |

## Verification
The bench targets the following corner cases and the faulty behaviour each would expose:
- Stalled ring on a descriptor that is not ready. A design that skipped it would issue extra memory requests.
- Irregular backpressure. A sequencer that advanced without a handshake would drop or repeat bytes, or place tx_last wrongly.
- Abort in the middle of a frame. A missed abort lets extra bytes through or reports done instead of error.
- Out-of-range lengths and a zero length. A broken limit check streams bytes it should refuse.
- Ring wrap by flag and by count. A wrong wrap sends a decoy descriptor in place of descriptor 0.
- Soft reset with a later descriptor pending. A soft reset that did not clear the index would leave descriptor 0 unsent.
- Clear-by-one interrupt bits. A wrong clear is seen as irq staying high, or the bits clearing on a write of 0.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

    // Descriptor control word layout (decoded by software)
    localparam int LEN_HI   = 31;
    localparam int LEN_LO   = 16;
    localparam int BIT_RDY  = 15;
    localparam int BIT_WRAP = 13;
    localparam int BIT_CRC  = 12;
    localparam int BIT_COLL = 11;

    // Register word addresses
    localparam int REG_MODE = 0;
    localparam int REG_INT  = 1;
    localparam int REG_MASK = 2;
    localparam int REG_LIM  = 3;
    localparam int REG_CNT  = 4;
    localparam int BD_BASE  = 8;

    // Mode bits
    localparam int MODE_EN  = 0;
    localparam int MODE_RST = 1;
    localparam int MODE_CRC = 2;

    // Interrupt source bits
    localparam int INT_DONE = 0;
    localparam int INT_ERR  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_BD,
        ST_FETCH,
        ST_WAIT_RD,
        ST_SEND,
        ST_WB
    } seq_state_e;

endpackage

// File: rtl/txseq_regs.sv
module txseq_regs
    import txseq_pkg::*;
#(
    parameter int CSR_AW = 5,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [31:0]       csr_wdata,
    input  logic              ev_done,
    input  logic              ev_err,
    output logic              mode_en,
    output logic              mode_rst,
    output logic              mode_crc,
    output logic [15:0]       min_len,
    output logic [15:0]       max_len,
    output logic [CNT_W-1:0]  bd_count,
    output logic [1:0]        int_src,
    output logic [1:0]        int_mask,
    output logic              irq,
    output logic [31:0]       reg_rdata
);

    typedef struct packed {
        logic [2:0]       mode;
        logic [1:0]       src;
        logic [1:0]       mask;
        logic [15:0]      minl;
        logic [15:0]      maxl;
        logic [CNT_W-1:0] cnt;
    } regs_s;

    regs_s r_d, r_q;

    logic wr_mode, wr_int, wr_mask, wr_lim, wr_cnt;

    always_comb begin
        wr_mode = csr_we && (csr_addr == CSR_AW'(REG_MODE));
        wr_int  = csr_we && (csr_addr == CSR_AW'(REG_INT));
        wr_mask = csr_we && (csr_addr == CSR_AW'(REG_MASK));
        wr_lim  = csr_we && (csr_addr == CSR_AW'(REG_LIM));
        wr_cnt  = csr_we && (csr_addr == CSR_AW'(REG_CNT));

        r_d = r_q;
        if (wr_mode) r_d.mode = csr_wdata[2:0];
        if (wr_mask) r_d.mask = csr_wdata[1:0];
        if (wr_lim) begin
            r_d.minl = csr_wdata[31:16];
            r_d.maxl = csr_wdata[15:0];
        end
        if (wr_cnt) r_d.cnt = csr_wdata[CNT_W-1:0];
        // clear-by-one, then new events (an event wins over a same-cycle clear)
        r_d.src = r_q.src & ~(wr_int ? csr_wdata[1:0] : 2'b00);
        r_d.src = r_d.src | {ev_err, ev_done};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        mode_en  = r_q.mode[MODE_EN];
        mode_rst = r_q.mode[MODE_RST];
        mode_crc = r_q.mode[MODE_CRC];
        min_len  = r_q.minl;
        max_len  = r_q.maxl;
        bd_count = r_q.cnt;
        int_src  = r_q.src;
        int_mask = r_q.mask;
        irq      = |(r_q.src & r_q.mask);
        unique case (csr_addr)
            CSR_AW'(REG_MODE): reg_rdata = {29'd0, r_q.mode};
            CSR_AW'(REG_INT):  reg_rdata = {30'd0, r_q.src};
            CSR_AW'(REG_MASK): reg_rdata = {30'd0, r_q.mask};
            CSR_AW'(REG_LIM):  reg_rdata = {r_q.minl, r_q.maxl};
            CSR_AW'(REG_CNT):  reg_rdata = 32'(r_q.cnt);
            default:           reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/txseq_bd_ram.sv
module txseq_bd_ram
    import txseq_pkg::*;
#(
    parameter int NUM_BD = 8,
    parameter int CSR_AW = 5,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [CSR_AW-1:0] sw_addr,
    input  logic [31:0]       sw_wdata,
    output logic              sw_hit,
    output logic [31:0]       sw_rdata,
    input  logic [IDX_W-1:0]  hw_idx,
    input  logic              hw_we,
    input  logic [31:0]       hw_wdata,
    output logic [31:0]       hw_word0,
    output logic [31:0]       hw_ptr
);

    localparam int WORDS = 2 * NUM_BD;
    localparam int WA_W  = $clog2(WORDS);

    logic [31:0]       ram_d [WORDS];
    logic [31:0]       ram_q [WORDS];
    logic [CSR_AW-1:0] off;
    logic [WA_W-1:0]   sw_wa;
    logic [WA_W-1:0]   hw_wa0;
    logic [WA_W-1:0]   hw_wa1;

    always_comb begin
        off    = sw_addr - CSR_AW'(BD_BASE);
        sw_hit = (sw_addr >= CSR_AW'(BD_BASE)) && (off < CSR_AW'(WORDS));
        sw_wa  = off[WA_W-1:0];
        hw_wa0 = WA_W'({hw_idx, 1'b0});
        hw_wa1 = WA_W'({hw_idx, 1'b1});

        for (int i = 0; i < WORDS; i++) ram_d[i] = ram_q[i];
        if (sw_we && sw_hit) ram_d[sw_wa] = sw_wdata;
        // the sequencer's status write-back wins over a software write to the same word
        if (hw_we) ram_d[hw_wa0] = hw_wdata;

        sw_rdata = sw_hit ? ram_q[sw_wa] : '0;
        hw_word0 = ram_q[hw_wa0];
        hw_ptr   = ram_q[hw_wa1];
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ram_q[g] <= '0;
            else        ram_q[g] <= ram_d[g];
        end
    end

endmodule

// File: rtl/txseq_seq.sv
module txseq_seq
    import txseq_pkg::*;
#(
    parameter int NUM_BD = 8,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic             mode_rst,
    input  logic             mode_crc,
    input  logic [15:0]      min_len,
    input  logic [15:0]      max_len,
    input  logic [CNT_W-1:0] bd_count,
    input  logic [31:0]      bd_word0,
    input  logic [31:0]      bd_ptr,
    output logic [IDX_W-1:0] bd_idx,
    output logic             wb_en,
    output logic [31:0]      wb_word,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [7:0]       mem_rdata,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    input  logic             tx_ready,
    input  logic             tx_abort,
    output logic             ev_done,
    output logic             ev_err
);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [31:0]      w0;
        logic [31:0]      ptr;
        logic [15:0]      len;
        logic [15:0]      cnt;
        logic             err;
        logic [7:0]       dat;
    } seq_s;

    seq_s s_d, s_q;

    logic [CNT_W-1:0] eff_cnt;
    logic [CNT_W-1:0] idx_plus;
    logic             ring_end;
    logic [15:0]      bd_len;
    logic             is_last;

    always_comb begin
        eff_cnt  = ((bd_count == '0) || (bd_count > CNT_W'(NUM_BD))) ? CNT_W'(NUM_BD) : bd_count;
        idx_plus = CNT_W'(s_q.idx) + CNT_W'(1);
        ring_end = s_q.w0[BIT_WRAP] || (idx_plus >= eff_cnt);
        bd_len   = bd_word0[LEN_HI:LEN_LO];
        is_last  = (s_q.cnt == s_q.len - 16'd1);

        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE: begin
                if (mode_en) s_d.state = ST_WAIT_BD;
            end
            ST_WAIT_BD: begin
                if (!mode_en) begin
                    s_d.state = ST_IDLE;
                end else if (bd_word0[BIT_RDY]) begin
                    s_d.w0           = bd_word0;
                    s_d.w0[BIT_CRC]  = mode_crc;
                    s_d.ptr          = bd_ptr;
                    s_d.len          = bd_len;
                    s_d.cnt          = '0;
                    if ((bd_len < min_len) || (bd_len > max_len)) begin
                        s_d.err   = 1'b1;
                        s_d.state = ST_WB;
                    end else if (bd_len == '0) begin
                        s_d.err   = 1'b0;
                        s_d.state = ST_WB;
                    end else begin
                        s_d.err   = 1'b0;
                        s_d.state = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (tx_abort) begin
                    s_d.err   = 1'b1;
                    s_d.state = ST_WB;
                end else begin
                    s_d.state = ST_WAIT_RD;
                end
            end
            ST_WAIT_RD: begin
                if (tx_abort) begin
                    s_d.err   = 1'b1;
                    s_d.state = ST_WB;
                end else if (mem_rvalid) begin
                    s_d.dat   = mem_rdata;
                    s_d.state = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_abort) begin
                    s_d.err   = 1'b1;
                    s_d.state = ST_WB;
                end else if (tx_ready) begin
                    s_d.cnt   = s_q.cnt + 16'd1;
                    s_d.state = is_last ? ST_WB : ST_FETCH;
                end
            end
            ST_WB: begin
                s_d.idx   = ring_end ? '0 : s_q.idx + IDX_W'(1);
                s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase

        if (mode_rst) begin
            s_d.state = ST_IDLE;
            s_d.idx   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    always_comb begin
        bd_idx   = s_q.idx;
        mem_req  = (s_q.state == ST_FETCH);
        mem_addr = s_q.ptr + 32'(s_q.cnt);
        tx_valid = (s_q.state == ST_SEND);
        tx_data  = s_q.dat;
        tx_last  = (s_q.state == ST_SEND) && is_last;
        wb_en    = (s_q.state == ST_WB);
        wb_word  = s_q.w0;
        wb_word[BIT_RDY] = 1'b0;
        if (s_q.err) wb_word[BIT_COLL] = 1'b0;
        ev_done  = wb_en && !s_q.err;
        ev_err   = wb_en && s_q.err;
    end

endmodule

// File: rtl/txseq_top.sv
module txseq_top
    import txseq_pkg::*;
#(
    parameter int  NUM_BD = 8,
    localparam int IDX_W  = (NUM_BD > 1) ? $clog2(NUM_BD) : 1,
    localparam int CNT_W  = $clog2(NUM_BD + 1),
    localparam int CSR_AW = $clog2(BD_BASE + 2 * NUM_BD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              tx_abort,
    output logic              irq
);

    logic             mode_en, mode_rst, mode_crc;
    logic [15:0]      min_len, max_len;
    logic [CNT_W-1:0] bd_count;
    logic [1:0]       int_src, int_mask;
    logic [31:0]      reg_rdata, ram_rdata;
    logic             ram_hit;
    logic             ev_done, ev_err;
    logic [IDX_W-1:0] bd_idx;
    logic             wb_en;
    logic [31:0]      wb_word, bd_word0, bd_ptr;

    txseq_regs #(.CSR_AW(CSR_AW), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .ev_done   (ev_done),
        .ev_err    (ev_err),
        .mode_en   (mode_en),
        .mode_rst  (mode_rst),
        .mode_crc  (mode_crc),
        .min_len   (min_len),
        .max_len   (max_len),
        .bd_count  (bd_count),
        .int_src   (int_src),
        .int_mask  (int_mask),
        .irq       (irq),
        .reg_rdata (reg_rdata)
    );

    txseq_bd_ram #(.NUM_BD(NUM_BD), .CSR_AW(CSR_AW), .IDX_W(IDX_W)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (csr_we),
        .sw_addr  (csr_addr),
        .sw_wdata (csr_wdata),
        .sw_hit   (ram_hit),
        .sw_rdata (ram_rdata),
        .hw_idx   (bd_idx),
        .hw_we    (wb_en),
        .hw_wdata (wb_word),
        .hw_word0 (bd_word0),
        .hw_ptr   (bd_ptr)
    );

    txseq_seq #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (mode_en),
        .mode_rst   (mode_rst),
        .mode_crc   (mode_crc),
        .min_len    (min_len),
        .max_len    (max_len),
        .bd_count   (bd_count),
        .bd_word0   (bd_word0),
        .bd_ptr     (bd_ptr),
        .bd_idx     (bd_idx),
        .wb_en      (wb_en),
        .wb_word    (wb_word),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready),
        .tx_abort   (tx_abort),
        .ev_done    (ev_done),
        .ev_err     (ev_err)
    );

    assign csr_rdata = ram_hit ? ram_rdata : reg_rdata;

endmodule

// File: rtl/txseq_chk.sv
module txseq_chk
    import txseq_pkg::*;
#(
    parameter int CSR_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_we,
    input logic [CSR_AW-1:0] csr_addr,
    input logic [31:0]       csr_wdata,
    input logic              mem_req,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              tx_ready,
    input logic              tx_abort,
    input logic              mode_rst,
    input logic [1:0]        int_src
);

    logic clr_done, clr_err;
    assign clr_done = csr_we && (csr_addr == CSR_AW'(REG_INT)) && csr_wdata[INT_DONE];
    assign clr_err  = csr_we && (csr_addr == CSR_AW'(REG_INT)) && csr_wdata[INT_ERR];

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !tx_abort |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    p_one_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_abort_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort && tx_valid |=> !tx_valid);

    p_sticky_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_src[INT_DONE] && !clr_done |=> int_src[INT_DONE]);

    p_sticky_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_src[INT_ERR] && !clr_err |=> int_src[INT_ERR]);

    p_soft_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rst |=> !tx_valid && !mem_req);

endmodule

bind txseq_top txseq_chk #(.CSR_AW(CSR_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .mem_req   (mem_req),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready),
    .tx_abort  (tx_abort),
    .mode_rst  (mode_rst),
    .int_src   (int_src)
);

// File: tb/txseq_top_tb.sv
module txseq_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NBD   = 8;
    localparam int AW    = 5;
    localparam int RDY   = 1 << 15;
    localparam int WRAPB = 1 << 13;
    localparam int CRCB  = 1 << 12;
    localparam int COLLB = 1 << 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 1'b0;
    logic [AW-1:0] csr_addr = '0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic          mem_req;
    logic [31:0]   mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [7:0]    mem_rdata = '0;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_last;
    logic          tx_ready = 1'b0;
    logic          tx_abort = 1'b0;
    logic          irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int acc = 0;
    int abort_at = -1;
    int memcnt = 0;
    bit finished = 1'b0;
    logic [8:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    txseq_top #(.NUM_BD(NBD)) u_dut (
        .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
        .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
        .tx_valid, .tx_data, .tx_last, .tx_ready, .tx_abort, .irq
    );

    // memory stub: one-cycle response, byte = low address byte xor 0x5A
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem_addr[7:0] ^ 8'h5A;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // reference stream model, compared every clock
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (abort_at >= 0 && acc == abort_at) begin
                tx_abort = 1'b1;
                tx_ready = 1'b0;
            end else begin
                tx_ready = (cyc % 3) != 1;
            end
            if (mem_req) memcnt++;
            if (tx_valid && tx_ready && !tx_abort) begin
                acc++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R4", "unexpected byte", {tx_last, tx_data}, 0);
                end else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    chk({tx_last, tx_data} == e, "R4", "byte/last", {tx_last, tx_data}, e);
                end
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = AW'(a); csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = AW'(a);
        #1 d = csr_rdata;
    endtask

    task automatic push(input int len, input int ptr, input int n);
        for (int k = 0; k < n; k++) begin
            logic [31:0] ad;
            ad = 32'(ptr + k);
            expq.push_back({(k == len - 1), ad[7:0] ^ 8'h5A});
        end
    endtask

    task automatic arm(input int i, input int len, input int ptr, input int flags);
        wr(9 + 2*i, 32'(ptr));
        wr(8 + 2*i, 32'((len << 16) | flags | RDY));
    endtask

    task automatic wait_int(input int bitn);
        logic [31:0] v;
        for (int t = 0; t < 3000; t++) begin
            rd(1, v);
            if (v[bitn]) return;
        end
        chk(1'b0, "R5", "interrupt never rose", 0, 1);
    endtask

    task automatic wait_free(input int i);
        logic [31:0] v;
        for (int t = 0; t < 3000; t++) begin
            rd(8 + 2*i, v);
            if (!v[15]) return;
        end
        chk(1'b0, "R9", "descriptor never completed", i, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int m0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(!irq && !tx_valid && !tx_last && !mem_req, "R1", "outputs after reset",
            {irq, tx_valid, tx_last, mem_req}, 0);
        for (int a = 0; a < 5; a++) begin
            rd(a, v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end

        wr(3, {16'd1, 16'd100});
        wr(2, 32'h3);

        // R2 transmit disabled
        arm(0, 5, 32'h10, 0);
        repeat (30) @(negedge clk);
        chk(memcnt == 0, "R2", "requests while disabled", memcnt, 0);
        rd(8, v);
        chk(v == 32'((5 << 16) | RDY), "R2", "descriptor untouched", v, (5 << 16) | RDY);

        // R4 R5 normal frame under backpressure
        push(5, 32'h10, 5);
        wr(0, 32'h1);
        wait_int(0);
        rd(8, v);
        chk(v == 32'(5 << 16), "R5", "word0 after done", v, 5 << 16);
        rd(1, v);
        chk(v == 32'h1, "R5", "done source only", v, 1);
        chk(irq == 1'b1, "R10", "irq with done and mask", irq, 1);

        // R3 stall on unready descriptor 1
        repeat (20) @(negedge clk);
        chk(memcnt == 5, "R3", "requests with next unready", memcnt, 5);

        // R10 clear semantics
        wr(1, 32'h0);
        rd(1, v);
        chk(v == 32'h1, "R10", "write 0 keeps source", v, 1);
        wr(1, 32'h1);
        rd(1, v);
        chk(v == 32'h0 && !irq, "R10", "write 1 clears", {irq, v[1:0]}, 0);
        wr(2, 32'h0);

        // R3 frame sent once ready appears
        push(3, 32'h40, 3);
        arm(1, 3, 32'h40, 0);
        wait_int(0);
        rd(1, v);
        chk(v == 32'h1 && !irq, "R10", "masked irq stays low", {irq, v[1:0]}, 1);
        wr(1, 32'h3);
        wr(2, 32'h3);

        // R8 delayed-CRC status
        wr(0, 32'h5);
        push(2, 32'h80, 2);
        arm(2, 2, 32'h80, 0);
        wait_int(0);
        rd(12, v);
        chk(v == 32'((2 << 16) | CRCB), "R8", "crc status bit", v, (2 << 16) | CRCB);
        rd(10, v);
        chk(v[12] == 1'b0, "R8", "earlier frame without crc flag", v[12], 0);
        wr(1, 32'h3);
        wr(0, 32'h1);

        // R6 abort after two bytes
        abort_at = acc + 2;
        push(6, 32'h90, 2);
        arm(3, 6, 32'h90, COLLB);
        wait_int(1);
        repeat (5) @(negedge clk);
        rd(14, v);
        chk(v == 32'(6 << 16), "R6", "ready and collision cleared", v, 6 << 16);
        rd(1, v);
        chk(v == 32'h2, "R6", "error source only", v, 2);
        chk(expq.size() == 0, "R6", "bytes before abort", expq.size(), 0);
        abort_at = -1;
        tx_abort = 1'b0;
        wr(1, 32'h3);

        // R7 too long, then zero length (below min) with wrap
        m0 = memcnt;
        arm(4, 200, 32'h0, 0);
        wait_int(1);
        rd(16, v);
        chk(v == 32'(200 << 16), "R7", "oversize written back", v, 200 << 16);
        wr(1, 32'h3);
        arm(5, 0, 32'h0, WRAPB);
        wait_int(1);
        rd(1, v);
        chk(v == 32'h2, "R7", "undersize flags error", v, 2);
        chk(memcnt == m0, "R7", "no fetch for bad length", memcnt, m0);
        wr(1, 32'h3);

        // R9 wrap flag returns to descriptor 0
        push(4, 32'hA0, 4);
        arm(0, 4, 32'hA0, 0);
        wait_free(0);
        wr(1, 32'h3);

        // R9 count register wraps after descriptor 1
        wr(4, 32'd2);
        push(1, 32'hB0, 1);
        push(1, 32'hD0, 1);
        arm(2, 2, 32'hC0, 0);
        arm(0, 1, 32'hD0, 0);
        arm(1, 1, 32'hB0, 0);
        wait_free(0);
        rd(12, v);
        chk(v[15] == 1'b1, "R9", "decoy beyond count untouched", v[15], 1);
        wr(12, 32'h0);
        wr(1, 32'h3);

        // R11 soft reset restarts at descriptor 0 (index now 1, not ready)
        arm(0, 2, 32'hE0, 0);
        m0 = memcnt;
        repeat (20) @(negedge clk);
        chk(memcnt == m0, "R11", "stalled before soft reset", memcnt, m0);
        push(2, 32'hE0, 2);
        wr(0, 32'h3);
        repeat (3) @(negedge clk);
        chk(!tx_valid && !mem_req, "R11", "held idle", {tx_valid, mem_req}, 0);
        wr(0, 32'h1);
        wait_free(0);
        repeat (5) @(negedge clk);
        chk(expq.size() == 0, "R4", "all expected bytes seen", expq.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule